// File: doc/BRIEF.md
# UART Transmit Host Registers with Level Interrupt and ID Readout

This block is the processor-facing half of a 16550-style serial transmitter. A byte-wide register bus with a 3-bit address, separate read and write strobes, and combinational read data gives software access to the divisor latches, a line control byte, an interrupt enable byte and a FIFO control byte. A transmit store sits behind the same bus. With the FIFO disabled it acts as a single holding byte. With the FIFO enabled it is a 64-entry queue with a programmable trigger level. A one-cycle `drain` strobe stands in for the serial shifter. Each strobe consumes the oldest byte, which is always visible on `tx_data`.

The single interrupt pin reports transmit demand. In FIFO mode it follows the fill level against the trigger threshold. With the FIFO off it follows the empty or full state of the holding byte. The pin's sense flips with the `intel_mode` input, so it serves both active-high and active-low hosts. When software programs both divisor latches to zero, reads of those two addresses return a fixed identification byte and a revision byte instead of the stored zeros.

Top module: `uart_tx_host`

## Requirements
- R1: After asynchronous reset (`rst_n` low), the following values hold: the low divisor reads 0x01, the high divisor reads 0x00, line control reads 0x00, FIFO control reads 0x00, the store is empty, and `irq` is high when `intel_mode` is high.
- R2: Register map. When line control bit 7 is set, address 0 is the low divisor and address 1 is the high divisor. When it is clear, a write to address 0 enters the transmit store and address 1 is the interrupt enable byte. Address 3 is line control. Address 2 takes FIFO control writes and reads back {2'b00, trigger[1:0], bit3, 2'b00, enable}. Address 5 reads status, with bit 0 the overflow flag and bit 1 the empty flag. Address 6 reads the fill count.
- R3: When both divisor latches hold 0x00 and line control bit 7 is set, address 1 reads 0x01 (identification) and address 0 reads 0x01 (revision). Otherwise the stored divisor values are read.
- R4: With FIFO control bit 0 clear, the store holds one byte. In Intel mode (`intel_mode`=1), `irq` is high while the store is empty and low while it holds a byte.
- R5: With FIFO control bit 0 set, the store holds 64 bytes. Bits 5:4 select the trigger: 00 selects 8, 01 selects 16, 10 selects 32 and 11 selects 56. In Intel mode, `irq` is low only while the count exceeds the trigger.
- R6: With `intel_mode` low, `irq` is the inverse of its Intel-mode level in every case.
- R7: A FIFO control write with bit 2 set, or one that changes bit 0, empties the store and clears the overflow flag. `irq` shows the empty level from the next clock, and bit 2 reads back as 0.
- R8: A write to a full store is dropped and sets the overflow flag. The flag stays set until a flush.
- R9: FIFO control bit 3 is stored and read back, but it changes no fill, drain or interrupt behaviour.
- R10: `tx_data` shows the oldest stored byte, and each `drain` pulse removes it. A drain on an empty store has no effect. A write and a drain in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational, zero when not reading |
| intel_mode | input | 1 | 1: active-high interrupt, 0: active-low |
| drain | input | 1 | Consume oldest byte (shifter stand-in) |
| tx_data | output | 8 | Oldest stored byte |
| irq | output | 1 | Transmit interrupt |

## Verification
A wrong fill count shows on `irq` in the same cycle that the count crosses the trigger. The bench therefore probes the pin at exactly trigger and trigger+1 for every trigger setting and in both polarities. A pointer slip shows as a wrong byte on `tx_data` at the next drain, which the scoreboard compares in FIFO order across a full 64-byte run. A lost or spurious overflow flag, or a latched ID condition, appears at the next status or divisor read. The bench reads these back directly after each write that could have disturbed them.

// File: rtl/uart_tx_host.sv
module uart_tx_host #(
  parameter int DEPTH = 64,
  parameter logic [7:0] ID_CODE = 8'h01,
  parameter logic [7:0] REV_CODE = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  input  logic       intel_mode,
  input  logic       drain,
  output logic [7:0] tx_data,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0] div_lo, div_hi, lcr, ier;
  logic       fifo_en, dma_bit, ovf;
  logic [1:0] trig_sel;
  logic [7:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, cap, trig_lvl;

  wire dlab    = lcr[7];
  wire thr_wr  = wr_en && addr == 3'd0 && !dlab;
  wire fcr_wr  = wr_en && addr == 3'd2;
  wire flush   = fcr_wr && (wdata[2] || wdata[0] != fifo_en);
  wire full    = count >= cap;
  wire push    = thr_wr && !full;
  wire pop     = drain && count != '0;
  wire div_zero = div_lo == 8'h00 && div_hi == 8'h00;

  assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = CW'(DEPTH / 8);
      2'd1:    trig_lvl = CW'(DEPTH / 4);
      2'd2:    trig_lvl = CW'(DEPTH / 2);
      default: trig_lvl = CW'(DEPTH - 8);
    endcase
  end

  wire tx_req = fifo_en ? (count <= trig_lvl) : (count == '0);
  assign irq = intel_mode ? tx_req : !tx_req;
  assign tx_data = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo <= 8'h01;
      div_hi <= 8'h00;
      lcr <= 8'h00;
      ier <= 8'h00;
      fifo_en <= 1'b0;
      dma_bit <= 1'b0;
      trig_sel <= 2'd0;
    end else if (wr_en) begin
      case (addr)
        3'd0: if (dlab) div_lo <= wdata;
        3'd1: if (dlab) div_hi <= wdata; else ier <= wdata;
        3'd2: begin
          fifo_en <= wdata[0];
          dma_bit <= wdata[3];
          trig_sel <= wdata[5:4];
        end
        3'd3: lcr <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count <= '0;
      ovf <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count <= '0;
      ovf <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (thr_wr && full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      case (addr)
        3'd0: rdata = dlab ? (div_zero ? REV_CODE : div_lo) : 8'h00;
        3'd1: rdata = dlab ? (div_zero ? ID_CODE : div_hi) : ier;
        3'd2: rdata = {2'b00, trig_sel, dma_bit, 2'b00, fifo_en};
        3'd3: rdata = lcr;
        3'd5: rdata = {6'd0, count == '0, ovf};
        3'd6: rdata = 8'(count);
        default: rdata = 8'h00;
      endcase
    end
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 |-> irq == intel_mode); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr && wdata[2] |=> count == '0 && !ovf); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr && count == cap && !drain |=> ovf && count == $past(count)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !fcr_wr |=> ovf); // R8
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap); // R5
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    drain && count == '0 && !wr_en |=> count == '0); // R10
endmodule

// File: tb/tb_uart_tx_host.sv
module tb_uart_tx_host;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic wr_en = 0, rd_en = 0, intel_mode = 1, drain = 0;
  logic [7:0] rdata, tx_data;
  logic irq;
  int checks = 0, errors = 0;
  int rd_q[$], tx_q[$];
  string rd_tag[$];

  always #4 clk = ~clk;

  uart_tx_host dut (.clk, .rst_n, .addr, .wdata, .wr_en, .rd_en, .rdata,
                    .intel_mode, .drain, .tx_data, .irq);

  always @(posedge clk) begin
    if (rd_en && rd_q.size() > 0) begin
      int e; string t;
      e = rd_q.pop_front(); t = rd_tag.pop_front();
      checks++;
      if (rdata !== 8'(e)) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", t, rdata, 8'(e));
      end
    end
    if (drain && tx_q.size() > 0) begin
      int e;
      e = tx_q.pop_front();
      checks++;
      if (tx_data !== 8'(e)) begin
        errors++;
        $display("FAIL R10: tx_data got %h expected %h", tx_data, 8'(e));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk); addr = a; rd_en = 1; rd_q.push_back(exp); rd_tag.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic drn(input int exp);
    @(negedge clk); drain = 1; if (exp >= 0) tx_q.push_back(exp);
    @(negedge clk); drain = 0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk); #1;
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run incomplete got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_irq(1, "R1");
    rd(3, 8'h00, "R1");
    rd(2, 8'h00, "R1");
    rd(6, 0, "R1");
    wr(3, 8'h80);
    rd(0, 8'h01, "R1");
    rd(1, 8'h00, "R1");
    wr(0, 8'h00);
    rd(1, 8'h01, "R3");
    rd(0, 8'h01, "R3");
    wr(1, 8'h12);
    rd(0, 8'h00, "R3");
    rd(1, 8'h12, "R3");
    wr(0, 8'h34);
    rd(0, 8'h34, "R3");
    wr(3, 8'h03);
    rd(3, 8'h03, "R2");
    wr(1, 8'h0F);
    rd(1, 8'h0F, "R2");
    rd(6, 0, "R2");
    // holding-byte mode
    chk_irq(1, "R4");
    wr(0, 8'hA5);
    chk_irq(0, "R4");
    rd(6, 1, "R4");
    wr(0, 8'h5A);
    rd(5, 8'h01, "R8");
    rd(6, 1, "R8");
    drn(8'hA5);
    chk_irq(1, "R4");
    rd(5, 8'h03, "R8");
    wr(2, 8'h04);
    rd(5, 8'h02, "R7");
    rd(2, 8'h00, "R7");
    intel_mode = 0;
    chk_irq(0, "R6");
    wr(0, 8'h77);
    chk_irq(1, "R6");
    drn(8'h77);
    intel_mode = 1;
    // FIFO mode, each trigger
    wr(2, 8'h01);
    rd(2, 8'h01, "R2");
    for (int t = 0; t < 4; t++) begin
      int lvl;
      lvl = (t == 0) ? 8 : (t == 1) ? 16 : (t == 2) ? 32 : 56;
      wr(2, 8'(8'h05 | (t << 4)));
      rd(6, 0, "R7");
      for (int i = 0; i < lvl; i++) wr(0, 8'(t * 64 + i + 1));
      chk_irq(1, "R5");
      wr(0, 8'(t * 64 + lvl + 1));
      chk_irq(0, "R5");
      intel_mode = 0;
      chk_irq(1, "R6");
      intel_mode = 1;
      if (t == 3) begin
        for (int i = lvl + 1; i < 64; i++) wr(0, 8'(t * 64 + i + 1));
        rd(6, 64, "R5");
        rd(5, 8'h00, "R8");
        wr(0, 8'hEE);
        rd(6, 64, "R8");
        rd(5, 8'h01, "R8");
        for (int i = 0; i < 64; i++) drn(8'(t * 64 + i + 1));
        chk_irq(1, "R10");
        drn(-1);
        rd(6, 0, "R10");
        rd(5, 8'h03, "R8");
      end
    end
    // legacy DMA bit has no effect
    wr(2, 8'h1D);
    rd(2, 8'h19, "R9");
    for (int i = 0; i < 16; i++) wr(0, 8'(i));
    chk_irq(1, "R9");
    wr(0, 8'h10);
    chk_irq(0, "R9");
    wr(2, 8'h1D);
    chk_irq(1, "R7");
    rd(6, 0, "R7");
    // write and drain together
    wr(0, 8'hC1);
    @(negedge clk); addr = 0; wdata = 8'hC2; wr_en = 1; drain = 1; tx_q.push_back(8'hC1);
    @(negedge clk); wr_en = 0; drain = 0;
    rd(6, 1, "R10");
    drn(8'hC2);
    // toggling enable flushes
    wr(0, 8'h01); wr(0, 8'h02);
    rd(6, 2, "R7");
    wr(2, 8'h00);
    rd(6, 0, "R7");
    chk_irq(1, "R7");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule